// File: doc/BRIEF.md
# Keypad Controller Register File

This block holds the software-visible state of a keypad controller that handles both a scanned key matrix and directly wired keys. It answers a single-cycle word bus carrying a valid strobe, a write flag, a byte address and write data, and returns read data one cycle after each accepted read. Ten 32-bit registers sit on an 8-byte stride: a control word, a direct-key word, a rotary-encoder word, a matrix-key word, an auto-scan status word, four multi-press bitmap words and a debounce-interval word.

Reads can change state. Reading the control word drops the interrupt line and clears both interrupt flags inside it; reading the rotary word clears the four encoder overflow/underflow flags; reading the matrix word clears its key-pressed flag. A separate key tracker drives set pulses for those flags and load strobes for the auto-scan status and bitmap words. When a set pulse lands in the cycle in which a read clears the same flag, the set wins, so no event is lost.

Top module: `kpd_regfile`

## Requirements
- R1: A synchronous active-high reset sets all ten registers to zero and drives `irq` and `rd_vld` low.
- R2: An accepted read (`req_vld`=1, `req_wr`=0) raises `rd_vld` in the next cycle with `rd_data` holding the register value from before the read; slots are at byte offsets 0x00 control, 0x08 direct key, 0x10 rotary, 0x18 matrix, 0x20 auto-scan status, 0x28 + 8·k bitmap word k (k = 0..3), 0x48 debounce interval.
- R3: Writes to the direct-key, auto-scan status, bitmap and debounce words store all 32 bits and read back unchanged.
- R4: A write to the control word stores the data with bit 30 (scan start command) forced to 0; all other bits are kept.
- R5: A read of the control word clears bit 22 (matrix interrupt flag) and bit 5 (direct interrupt flag) and drops `irq` from the next cycle.
- R6: A read of the rotary word clears bits 31, 30, 15 and 14 and leaves every other bit as it was.
- R7: A read of the matrix word clears bit 31 and leaves every other bit as it was.
- R8: An address that is not a multiple of 8 or lies at 0x50 or above reads as zero, and a write to it changes no register.
- R9: A pulse on `hw_mi_set` sets control bit 22 and a pulse on `hw_di_set` sets control bit 5; either raises `irq` in the next cycle, and `irq` stays high until a control-word read.
- R10: A set pulse in the same cycle as a read that would clear the same flag wins: the flag and `irq` stay set, while the read returns the prior value.
- R11: `hw_rot_set` bits 0, 1, 2, 3 set rotary bits 14, 15, 30, 31; `hw_mat_set` sets matrix bit 31.
- R12: `hw_scan_we` loads `hw_scan_val` into the auto-scan status word and `hw_bmp_we[k]` loads bits [32k+31:32k] of `hw_bmp_val` into bitmap word k; a software write to the same word in the same cycle takes priority.
- R13: A cycle with `req_vld` low has no read side effect, whatever the address and write flag show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Bus request valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data |
| rd_vld | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Interrupt request |
| hw_mi_set | input | 1 | Tracker pulse: set matrix interrupt flag |
| hw_di_set | input | 1 | Tracker pulse: set direct interrupt flag |
| hw_rot_set | input | 4 | Tracker pulses: set rotary overflow/underflow flags |
| hw_mat_set | input | 1 | Tracker pulse: set matrix key-pressed flag |
| hw_scan_we | input | 1 | Tracker load strobe for the auto-scan status word |
| hw_scan_val | input | 32 | Auto-scan status load value |
| hw_bmp_we | input | 4 | Tracker load strobes, one per bitmap word |
| hw_bmp_val | input | 128 | Bitmap load values, word k at bits [32k+31:32k] |

## Verification
The properties assume the tracker gates its own set pulses with the interrupt enable, so every `hw_mi_set` or `hw_di_set` pulse is expected to raise `irq`; they also assume a single request per cycle, with no overlap of read and write. The bench drives one bus request at a time, always on the falling edge, and keeps all tracker inputs low except during the one-cycle pulses and loads it aims at a particular requirement, including the deliberate same-cycle collisions for R10 and R12.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned NUM_SLOTS = 10;
   localparam int unsigned NUM_BMP   = 4;
   localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);
   localparam int unsigned STRIDE_LSB = 3;

   localparam int unsigned SLOT_CTRL   = 0;
   localparam int unsigned SLOT_DIRECT = 1;
   localparam int unsigned SLOT_ROT    = 2;
   localparam int unsigned SLOT_MAT    = 3;
   localparam int unsigned SLOT_SCAN   = 4;
   localparam int unsigned SLOT_BMP0   = 5;
   localparam int unsigned SLOT_DEB    = 9;

   localparam int unsigned BIT_SCAN_GO = 30;
   localparam int unsigned BIT_MINT    = 22;
   localparam int unsigned BIT_DINT    = 5;
   localparam int unsigned BIT_MPRESS  = 31;

   localparam logic [WORD_W-1:0] ROT_FLAGS = 32'hC000_C000;

   // bits cleared by an accepted read of the slot
   function automatic logic [WORD_W-1:0] rc_mask(int unsigned slot);
      logic [WORD_W-1:0] m;
      m = '0;
      if (slot == SLOT_CTRL) begin
         m[BIT_MINT] = 1'b1;
         m[BIT_DINT] = 1'b1;
      end else if (slot == SLOT_ROT) begin
         m = ROT_FLAGS;
      end else if (slot == SLOT_MAT) begin
         m[BIT_MPRESS] = 1'b1;
      end
      return m;
   endfunction

   // bits forced low on a software write
   function automatic logic [WORD_W-1:0] wz_mask(int unsigned slot);
      logic [WORD_W-1:0] m;
      m = '0;
      if (slot == SLOT_CTRL) m[BIT_SCAN_GO] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/kpd_decode.sv
module kpd_decode
   import kpd_pkg::*;
#(
   parameter int unsigned AW = 8
) (
   input  logic [AW-1:0]     addr,
   output logic              hit,
   output logic [SLOT_W-1:0] slot
);
   localparam int unsigned IDX_W = AW - STRIDE_LSB;

   logic [IDX_W-1:0] idx;

   assign idx  = addr[AW-1:STRIDE_LSB];
   assign hit  = (addr[STRIDE_LSB-1:0] == '0) && (idx < IDX_W'(NUM_SLOTS));
   assign slot = idx[SLOT_W-1:0];
endmodule

// File: rtl/kpd_word_reg.sv
module kpd_word_reg
   import kpd_pkg::*;
#(
   parameter logic [WORD_W-1:0] RC_MASK = '0,
   parameter logic [WORD_W-1:0] WZ_MASK = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sw_we,
   input  logic [WORD_W-1:0] sw_wdata,
   input  logic              rd_clr,
   input  logic [WORD_W-1:0] hw_set,
   input  logic              hw_ld,
   input  logic [WORD_W-1:0] hw_ld_val,
   output logic [WORD_W-1:0] q
);
   logic [WORD_W-1:0] base;
   logic [WORD_W-1:0] nxt;

   always_comb begin
      base = q;
      if (sw_we)      base = sw_wdata & ~WZ_MASK;
      else if (hw_ld) base = hw_ld_val;
      if (rd_clr)     base = base & ~RC_MASK;
      nxt = base | hw_set;
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
   end
endmodule

// File: rtl/kpd_irq.sv
module kpd_irq (
   input  logic clk,
   input  logic rst,
   input  logic set_any,
   input  logic clr,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (rst)          irq <= 1'b0;
      else if (set_any) irq <= 1'b1;
      else if (clr)     irq <= 1'b0;
   end
endmodule

// File: rtl/kpd_regfile.sv
module kpd_regfile
   import kpd_pkg::*;
#(
   parameter int unsigned AW = 8
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      req_vld,
   input  logic                      req_wr,
   input  logic [AW-1:0]             req_addr,
   input  logic [WORD_W-1:0]         req_wdata,
   output logic                      rd_vld,
   output logic [WORD_W-1:0]         rd_data,
   output logic                      irq,
   input  logic                      hw_mi_set,
   input  logic                      hw_di_set,
   input  logic [3:0]                hw_rot_set,
   input  logic                      hw_mat_set,
   input  logic                      hw_scan_we,
   input  logic [WORD_W-1:0]         hw_scan_val,
   input  logic [NUM_BMP-1:0]        hw_bmp_we,
   input  logic [NUM_BMP*WORD_W-1:0] hw_bmp_val
);
   generate
      if (AW < 7 || AW > 32) begin : g_bad_aw
         $error("kpd_regfile: AW must lie in 7..32");
      end
      if (SLOT_BMP0 + NUM_BMP > SLOT_DEB) begin : g_bad_map
         $error("kpd_regfile: bitmap slots overlap the debounce slot");
      end
   endgenerate

   logic              hit;
   logic [SLOT_W-1:0] slot;
   logic              rd_acc;
   logic              wr_acc;

   logic [WORD_W-1:0]    q_arr   [NUM_SLOTS];
   logic [WORD_W-1:0]    set_arr [NUM_SLOTS];
   logic [WORD_W-1:0]    ldv_arr [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] ld_vec;
   logic [NUM_SLOTS-1:0] we_vec;
   logic [NUM_SLOTS-1:0] rc_vec;
   logic [WORD_W-1:0]    rd_mux;

   assign rd_acc = req_vld & ~req_wr;
   assign wr_acc = req_vld &  req_wr;

   kpd_decode #(.AW(AW)) u_dec (
      .addr (req_addr),
      .hit  (hit),
      .slot (slot)
   );

   always_comb begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
         set_arr[s] = '0;
         ldv_arr[s] = '0;
         ld_vec[s]  = 1'b0;
         we_vec[s]  = wr_acc && hit && (slot == SLOT_W'(s));
         rc_vec[s]  = rd_acc && hit && (slot == SLOT_W'(s));
      end
      set_arr[SLOT_CTRL][BIT_MINT] = hw_mi_set;
      set_arr[SLOT_CTRL][BIT_DINT] = hw_di_set;
      set_arr[SLOT_ROT][14]        = hw_rot_set[0];
      set_arr[SLOT_ROT][15]        = hw_rot_set[1];
      set_arr[SLOT_ROT][30]        = hw_rot_set[2];
      set_arr[SLOT_ROT][31]        = hw_rot_set[3];
      set_arr[SLOT_MAT][BIT_MPRESS] = hw_mat_set;
      ld_vec[SLOT_SCAN]  = hw_scan_we;
      ldv_arr[SLOT_SCAN] = hw_scan_val;
      for (int k = 0; k < NUM_BMP; k++) begin
         ld_vec[SLOT_BMP0+k]  = hw_bmp_we[k];
         ldv_arr[SLOT_BMP0+k] = hw_bmp_val[k*WORD_W +: WORD_W];
      end
   end

   genvar gs;
   generate
      for (gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
         kpd_word_reg #(
            .RC_MASK (rc_mask(gs)),
            .WZ_MASK (wz_mask(gs))
         ) u_reg (
            .clk       (clk),
            .rst       (rst),
            .sw_we     (we_vec[gs]),
            .sw_wdata  (req_wdata),
            .rd_clr    (rc_vec[gs]),
            .hw_set    (set_arr[gs]),
            .hw_ld     (ld_vec[gs]),
            .hw_ld_val (ldv_arr[gs]),
            .q         (q_arr[gs])
         );
      end
   endgenerate

   kpd_irq u_irq (
      .clk     (clk),
      .rst     (rst),
      .set_any (hw_mi_set | hw_di_set),
      .clr     (rc_vec[SLOT_CTRL]),
      .irq     (irq)
   );

   always_comb begin
      rd_mux = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (hit && slot == SLOT_W'(s)) rd_mux = q_arr[s];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_vld  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_vld <= rd_acc;
         if (rd_acc) rd_data <= rd_mux;
      end
   end
endmodule

// File: rtl/kpd_regfile_chk.sv
module kpd_regfile_chk #(
   parameter int unsigned AW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          req_vld,
   input logic          req_wr,
   input logic [AW-1:0] req_addr,
   input logic          rd_vld,
   input logic [31:0]   rd_data,
   input logic          irq,
   input logic          hw_mi_set,
   input logic          hw_di_set
);
   logic rd_req;
   logic ctrl_rd;
   logic off_map;

   assign rd_req  = req_vld && !req_wr;
   assign ctrl_rd = rd_req && (req_addr == '0);
   assign off_map = (req_addr[2:0] != 3'd0) || (req_addr >= AW'(8'h50));

   // R1
   a_r1_reset_clear: assert property (@(posedge clk) rst |=> (!irq && !rd_vld));

   // R2
   a_r2_rd_vld_follows: assert property (@(posedge clk) disable iff (rst)
      rd_req |=> rd_vld);
   a_r2_no_spurious_vld: assert property (@(posedge clk) disable iff (rst)
      !rd_req |=> !rd_vld);

   // R5
   a_r5_irq_drop: assert property (@(posedge clk) disable iff (rst)
      (ctrl_rd && !hw_mi_set && !hw_di_set) |=> !irq);

   // R8
   a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
      (rd_req && off_map) |=> (rd_data == 32'd0));

   // R9
   a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
      (hw_mi_set || hw_di_set) |=> irq);

   // R10
   a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
      (ctrl_rd && hw_mi_set) |=> irq);

   // R13
   a_r13_idle_keeps_irq: assert property (@(posedge clk) disable iff (rst)
      (!req_vld && !hw_mi_set && !hw_di_set) |=> $stable(irq));
endmodule

bind kpd_regfile kpd_regfile_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_vld   (req_vld),
   .req_wr    (req_wr),
   .req_addr  (req_addr),
   .rd_vld    (rd_vld),
   .rd_data   (rd_data),
   .irq       (irq),
   .hw_mi_set (hw_mi_set),
   .hw_di_set (hw_di_set)
);

// File: tb/kpd_regfile_tb.sv
`timescale 1ns/1ps
module kpd_regfile_tb;
   localparam int AW = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         req_vld = 1'b0;
   logic         req_wr = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]  req_wdata = '0;
   logic         rd_vld;
   logic [31:0]  rd_data;
   logic         irq;
   logic         hw_mi_set = 1'b0;
   logic         hw_di_set = 1'b0;
   logic [3:0]   hw_rot_set = '0;
   logic         hw_mat_set = 1'b0;
   logic         hw_scan_we = 1'b0;
   logic [31:0]  hw_scan_val = '0;
   logic [3:0]   hw_bmp_we = '0;
   logic [127:0] hw_bmp_val = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   kpd_regfile #(.AW(AW)) u_dut (
      .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_vld(rd_vld),
      .rd_data(rd_data), .irq(irq), .hw_mi_set(hw_mi_set),
      .hw_di_set(hw_di_set), .hw_rot_set(hw_rot_set), .hw_mat_set(hw_mat_set),
      .hw_scan_we(hw_scan_we), .hw_scan_val(hw_scan_val),
      .hw_bmp_we(hw_bmp_we), .hw_bmp_val(hw_bmp_val)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data as results appear
   always @(negedge clk) begin
      if (!rst && rd_vld) begin
         if (exp_q.size() == 0) begin
            check(rd_data, 32'hxxxx_xxxx, "R2 unexpected read response");
         end else begin
            check(rd_data, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      req_vld = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_vld = 1'b0; req_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      req_vld = 1'b1; req_wr = 1'b0; req_addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check({31'd0, irq}, 32'd0, "R1 irq low in reset");
      check({31'd0, rd_vld}, 32'd0, "R1 rd_vld low in reset");
      rst = 1'b0;
      for (int s = 0; s < 10; s++) bus_rd(AW'(s*8), 32'd0, "R1 register zero after reset");

      // control word: bit 30 dropped, then clear-on-read of 22 and 5
      bus_wr(8'h00, 32'hFFFF_FFFF);
      bus_rd(8'h00, 32'hBFFF_FFFF, "R4 control write drops bit 30");
      bus_rd(8'h00, 32'hBFBF_FFDF, "R5 control read clears bits 22 and 5");

      // plain words
      bus_wr(8'h08, 32'h1234_5678);
      bus_wr(8'h20, 32'hA5A5_0F0F);
      for (int k = 0; k < 4; k++) bus_wr(AW'(8'h28 + k*8), 32'h1111_1111 * (k+1));
      bus_wr(8'h48, 32'h0000_00FF);
      bus_rd(8'h08, 32'h1234_5678, "R3 direct key readback");
      bus_rd(8'h20, 32'hA5A5_0F0F, "R3 scan status readback");
      for (int k = 0; k < 4; k++)
         bus_rd(AW'(8'h28 + k*8), 32'h1111_1111 * (k+1), "R3 bitmap readback");
      bus_rd(8'h48, 32'h0000_00FF, "R2 debounce offset readback");
      bus_rd(8'h48, 32'h0000_00FF, "R3 debounce read has no side effect");

      // rotary and matrix clear-on-read
      bus_wr(8'h10, 32'hFFFF_FFFF);
      bus_rd(8'h10, 32'hFFFF_FFFF, "R6 rotary read returns prior value");
      bus_rd(8'h10, 32'h3FFF_3FFF, "R6 rotary flags cleared");
      bus_wr(8'h18, 32'hFFFF_FFFF);
      bus_rd(8'h18, 32'hFFFF_FFFF, "R7 matrix read returns prior value");
      bus_rd(8'h18, 32'h7FFF_FFFF, "R7 matrix pressed flag cleared");

      // unmapped
      bus_rd(8'h50, 32'd0, "R8 read beyond map");
      bus_rd(8'h0C, 32'd0, "R8 read misaligned");
      bus_wr(8'h0C, 32'hDEAD_BEEF);
      bus_wr(8'h58, 32'hDEAD_BEEF);
      bus_wr(8'h09, 32'hDEAD_BEEF);
      bus_rd(8'h08, 32'h1234_5678, "R8 unmapped write left direct word");
      bus_rd(8'h10, 32'h3FFF_3FFF, "R8 unmapped write left rotary word");
      bus_rd(8'h48, 32'h0000_00FF, "R8 unmapped write left debounce word");

      // hardware interrupt sets
      bus_wr(8'h00, 32'h0000_0000);
      @(negedge clk); hw_mi_set = 1'b1;
      @(negedge clk); hw_mi_set = 1'b0;
      check({31'd0, irq}, 32'd1, "R9 irq raised by matrix set");
      req_addr = 8'h00; req_wr = 1'b0;
      repeat (4) @(negedge clk);
      check({31'd0, irq}, 32'd1, "R13 idle cycles keep irq");
      bus_rd(8'h00, 32'h0040_0000, "R9 matrix flag set, R13 not cleared by idle");
      check({31'd0, irq}, 32'd0, "R5 irq dropped by control read");
      bus_rd(8'h00, 32'd0, "R5 matrix flag cleared");
      @(negedge clk); hw_di_set = 1'b1;
      @(negedge clk); hw_di_set = 1'b0;
      check({31'd0, irq}, 32'd1, "R9 irq raised by direct set");
      bus_rd(8'h00, 32'h0000_0020, "R9 direct flag set");
      check({31'd0, irq}, 32'd0, "R5 irq dropped after direct flag read");

      // set collides with clear-on-read
      @(negedge clk);
      req_vld = 1'b1; req_wr = 1'b0; req_addr = 8'h00; hw_mi_set = 1'b1;
      exp_q.push_back(32'd0); tag_q.push_back("R10 colliding read returns prior value");
      @(negedge clk);
      req_vld = 1'b0; hw_mi_set = 1'b0;
      check({31'd0, irq}, 32'd1, "R10 irq kept when set meets clear");
      bus_rd(8'h00, 32'h0040_0000, "R10 flag kept when set meets clear");

      // rotary / matrix hardware sets
      @(negedge clk); hw_rot_set = 4'b0101; hw_mat_set = 1'b1;
      @(negedge clk); hw_rot_set = 4'b0000; hw_mat_set = 1'b0;
      bus_rd(8'h10, 32'h7FFF_7FFF, "R11 rotary bits 14 and 30 set");
      bus_rd(8'h18, 32'hFFFF_FFFF, "R11 matrix pressed flag set");
      @(negedge clk); hw_rot_set = 4'b1010;
      @(negedge clk); hw_rot_set = 4'b0000;
      bus_rd(8'h10, 32'h3FFF_3FFF | 32'h8000_8000, "R11 rotary bits 15 and 31 set");

      // status loads
      @(negedge clk);
      hw_scan_we = 1'b1; hw_scan_val = 32'h0400_0012;
      hw_bmp_we = 4'b0100; hw_bmp_val[2*32 +: 32] = 32'h0003_0100;
      @(negedge clk);
      hw_scan_we = 1'b0; hw_bmp_we = 4'b0000;
      bus_rd(8'h20, 32'h0400_0012, "R12 scan status loaded");
      bus_rd(8'h38, 32'h0003_0100, "R12 bitmap word 2 loaded");
      @(negedge clk);
      req_vld = 1'b1; req_wr = 1'b1; req_addr = 8'h30; req_wdata = 32'hCAFE_F00D;
      hw_bmp_we = 4'b0010; hw_bmp_val[1*32 +: 32] = 32'h0BAD_0BAD;
      @(negedge clk);
      req_vld = 1'b0; req_wr = 1'b0; hw_bmp_we = 4'b0000;
      bus_rd(8'h30, 32'hCAFE_F00D, "R12 software write beats load");

      repeat (3) @(negedge clk);
      check(32'(exp_q.size()), 32'd0, "R2 all reads answered");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule